// File: doc/BRIEF.md
# Serial Register Port for a Timekeeping Peripheral

This block is the serial target through which a host reads and writes the register space of a real-time clock peripheral. A transaction opens when chip select goes high. The first byte carries a direction bit and a 7-bit start address. Each byte after it moves one data byte to or from the next address in turn, so a single transaction can cover a run of consecutive registers. SCLK idles low. The host changes MOSI on the rising edge and samples MISO on the falling edge. The target works from a fast system clock, and SCLK, chip select and MOSI are synchronised into that clock.

The block holds a control register, an alarm status register, a charger configuration register and a 96-byte scratch RAM. Every other address is passed to the neighbouring timekeeping blocks over a simple strobe bus. A write-protect bit in the control register blocks every host write except a write to the control register itself.

Top module: `rtcspi_target`

## Requirements
- R1: Command byte bit 7 set selects a write transaction and bit 7 clear selects a read. Bits 6:0 give the start address.
- R2: Each further byte uses the address after the previous one, and the address wraps from 0x7F to 0x00.
- R3: Chip select is active high. MOSI is captured on falling SCLK, MSB first. MISO changes after rising SCLK, MSB first, and is held at 0 while chip select is low. The first read byte comes from the start address.
- R4: The control register sits at 0x0F. Bit 7 is the active-low oscillator enable and bit 6 is write protect. Bits 5:3 always read 0. After reset it holds 0xC0, and ctrl_o mirrors it.
- R5: While control bit 6 is 1, a write to any address other than 0x0F changes nothing: there is no bus_wr_o strobe and no internal register or RAM byte is altered.
- R6: The status register sits at 0x10. Bit n is set to 1 in the clock cycle after alarm_i[n] is high. A host write loads bits 1:0, and an alarm set in the same cycle wins. Bits 7:2 read 0.
- R7: The charger configuration register sits at 0x11 as a full 8-bit read/write register, and trickle_o mirrors it.
- R8: Addresses 0x20 to 0x7F read and write a 96-byte RAM.
- R9: Addresses 0x00 to 0x0E and 0x12 to 0x1F are external. A write gives a one-cycle bus_wr_o with bus_addr_o and bus_wdata_o. A read gives a one-cycle bus_rd_o, and bus_rdata_i is taken in that same cycle. bus_rd_o and bus_wr_o are never high together.
- R10: If chip select drops in the middle of a byte, that partial byte is discarded, and the next transaction starts with a command byte.
- R11: After reset, miso_o is 0, no bus strobe is active, status is 0, the charger register is 0 and the RAM is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x SCLK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host, idle low |
| cs_i | input | 1 | Chip select, active high |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| bus_addr_o | output | 7 | Address of the current access |
| bus_rd_o | output | 1 | Read strobe for external addresses |
| bus_wr_o | output | 1 | Write strobe for external addresses |
| bus_wdata_o | output | 8 | Write data for external addresses |
| bus_rdata_i | input | 8 | Read data from neighbours, valid in the bus_rd_o cycle |
| alarm_i | input | 2 | Alarm match pulses that set the status flags |
| ctrl_o | output | 8 | Control register contents |
| trickle_o | output | 8 | Charger configuration contents |
| alarm_flag_o | output | 2 | Status flags |

## Verification
Directed transactions first read the reset values. They then try writes with protection set and check that nothing changes, walk bursts across the boundaries between register kinds (external to control to status to charger), and wrap the address from the top of RAM to external address 0. This tells correct address stepping apart from a stuck or double-incremented pointer, and correct region decode apart from aliasing. Transactions cut off mid-byte, both in the command and in a data byte, show whether partial bytes are discarded and whether the phase returns to command. Seeded random read and write bursts over RAM, the charger register and external space are then compared against a bench model of the register file, which exposes data-path or MSB-order faults under varied data.

// File: rtl/rtcspi_pkg.sv
package rtcspi_pkg;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = DATA_W - 1;
  localparam int RAM_DEPTH = 96;
  localparam int FLAG_W    = 2;
  localparam int WP_BIT    = 6;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h0F;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 7'h10;
  localparam logic [ADDR_W-1:0] TRK_ADDR  = 7'h11;
  localparam logic [ADDR_W-1:0] RAM_BASE  = 7'h20;

  localparam logic [DATA_W-1:0] CTRL_RST  = 8'hC0;
  localparam logic [DATA_W-1:0] CTRL_KEEP = 8'hC7;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;
  typedef enum logic [2:0] {RG_EXT, RG_CTRL, RG_STAT, RG_TRK, RG_RAM} region_e;

  function automatic region_e region_of(input logic [ADDR_W-1:0] a);
    if (a == CTRL_ADDR) return RG_CTRL;
    if (a == STAT_ADDR) return RG_STAT;
    if (a == TRK_ADDR)  return RG_TRK;
    if (int'(a) >= int'(RAM_BASE) && int'(a) < int'(RAM_BASE) + RAM_DEPTH) return RG_RAM;
    return RG_EXT;
  endfunction
endpackage

// File: rtl/rtcspi_sync.sv
module rtcspi_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/rtcspi_shift.sv
module rtcspi_shift
  import rtcspi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              mosi_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              miso_o
);
  localparam int BIT_W = $clog2(DATA_W);

  logic              sclk_q;
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [DATA_W-2:0] rx_sh_q;
  logic [DATA_W-1:0] tx_sh_q, rx_q;
  logic              miso_q, done_q;
  logic              rise, fall;

  assign rise = cs_i &  sclk_i & ~sclk_q;
  assign fall = cs_i & ~sclk_i &  sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
      tx_sh_q   <= '0;
      rx_q      <= '0;
      miso_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      done_q <= 1'b0;
      if (!cs_i) begin
        // partial byte dropped
        bit_cnt_q <= '0;
        tx_sh_q   <= '0;
        miso_q    <= 1'b0;
      end else begin
        if (fall) begin
          rx_sh_q   <= {rx_sh_q[DATA_W-3:0], mosi_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == BIT_W'(DATA_W-1)) begin
            done_q <= 1'b1;
            rx_q   <= {rx_sh_q, mosi_i};
          end
        end
        if (rise) begin
          miso_q  <= tx_sh_q[DATA_W-1];
          tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
        end
        if (load_i) tx_sh_q <= load_data_i;
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign miso_o = miso_q;
endmodule

// File: rtl/rtcspi_regs.sv
module rtcspi_regs
  import rtcspi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [FLAG_W-1:0] alarm_i,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] trk_o,
  output logic [FLAG_W-1:0] flag_o
);
  logic [DATA_W-1:0] ctrl_q, trk_q, ram_rd;
  logic [FLAG_W-1:0] flag_q;
  logic [DATA_W-1:0] ram_q [RAM_DEPTH];
  logic [ADDR_W-1:0] ram_idx;
  region_e           rg;
  logic              wr_ok;

  assign rg      = region_of(addr_i);
  assign ram_idx = addr_i - RAM_BASE;
  // protection never blocks the control register itself
  assign wr_ok   = wr_i & (~ctrl_q[WP_BIT] | (rg == RG_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      trk_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_ok && rg == RG_CTRL) ctrl_q <= wdata_i & CTRL_KEEP;
      if (wr_ok && rg == RG_TRK)  trk_q  <= wdata_i;
      flag_q <= ((wr_ok && rg == RG_STAT) ? wdata_i[FLAG_W-1:0] : flag_q) | alarm_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
    end else if (wr_ok && rg == RG_RAM) begin
      for (int i = 0; i < RAM_DEPTH; i++)
        if (ram_idx == ADDR_W'(i)) ram_q[i] <= wdata_i;
    end
  end

  always_comb begin
    ram_rd = '0;
    for (int i = 0; i < RAM_DEPTH; i++)
      if (ram_idx == ADDR_W'(i)) ram_rd = ram_q[i];
  end

  always_comb begin
    unique case (rg)
      RG_CTRL: rdata_o = ctrl_q;
      RG_STAT: rdata_o = {{(DATA_W-FLAG_W){1'b0}}, flag_q};
      RG_TRK:  rdata_o = trk_q;
      RG_RAM:  rdata_o = ram_rd;
      default: rdata_o = bus_rdata_i;
    endcase
  end

  assign bus_rd_o = rd_i  & (rg == RG_EXT);
  assign bus_wr_o = wr_ok & (rg == RG_EXT);
  assign ctrl_o   = ctrl_q;
  assign trk_o    = trk_q;
  assign flag_o   = flag_q;
endmodule

// File: rtl/rtcspi_target.sv
module rtcspi_target
  import rtcspi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic [FLAG_W-1:0] alarm_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] trickle_o,
  output logic [FLAG_W-1:0] alarm_flag_o
);
  logic [2:0]        pins_s;
  logic              sclk_s, cs_s, mosi_s;
  logic              done;
  logic [DATA_W-1:0] rx_b, rdata;
  phase_e            phase_q;
  logic              wr_q;
  logic [ADDR_W-1:0] ptr_q, acc_addr;
  logic              acc_rd, acc_wr, is_cmd;

  rtcspi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({sclk_i, cs_i, mosi_i}), .q_o(pins_s)
  );
  assign {sclk_s, cs_s, mosi_s} = pins_s;

  rtcspi_shift u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sclk_i(sclk_s), .cs_i(cs_s), .mosi_i(mosi_s),
    .load_i(acc_rd), .load_data_i(rdata),
    .done_o(done), .rx_o(rx_b), .miso_o(miso_o)
  );

  assign is_cmd   = (phase_q == PH_CMD);
  assign acc_addr = is_cmd ? rx_b[ADDR_W-1:0] : ptr_q;
  // reads prefetch the byte that the next data slot shifts out
  assign acc_rd   = done & (is_cmd ? ~rx_b[DATA_W-1] : ~wr_q);
  assign acc_wr   = done & ~is_cmd & wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      wr_q    <= 1'b0;
      ptr_q   <= '0;
    end else if (!cs_s) begin
      phase_q <= PH_CMD;
    end else if (done) begin
      if (is_cmd) begin
        phase_q <= PH_DATA;
        wr_q    <= rx_b[DATA_W-1];
        ptr_q   <= rx_b[DATA_W-1] ? rx_b[ADDR_W-1:0] : rx_b[ADDR_W-1:0] + 1'b1;
      end else begin
        ptr_q   <= ptr_q + 1'b1;
      end
    end
  end

  rtcspi_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .addr_i(acc_addr), .rd_i(acc_rd), .wr_i(acc_wr), .wdata_i(rx_b),
    .rdata_o(rdata), .alarm_i(alarm_i),
    .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o), .bus_rdata_i(bus_rdata_i),
    .ctrl_o(ctrl_o), .trk_o(trickle_o), .flag_o(alarm_flag_o)
  );

  assign bus_addr_o  = acc_addr;
  assign bus_wdata_o = rx_b;
endmodule

// File: rtl/rtcspi_target_chk.sv
module rtcspi_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cs_i,
  input logic       miso_o,
  input logic       bus_rd_o,
  input logic       bus_wr_o,
  input logic [1:0] alarm_i,
  input logic [7:0] ctrl_o,
  input logic [1:0] alarm_flag_o
);
  p_rw_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));

  p_wr_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o |=> !bus_wr_o);

  p_rd_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rd_o |=> !bus_rd_o);

  p_wp_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o |-> !ctrl_o[6]);

  p_ctrl_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[5:3] == 3'b000);

  p_flag0_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i[0] |=> alarm_flag_o[0]);

  p_flag1_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_i[1] |=> alarm_flag_o[1]);

  // window fits the default two-stage synchroniser
  p_miso_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_i && $past(!cs_i) && $past(!cs_i, 2) && $past(!cs_i, 3)) |-> !miso_o);
endmodule

bind rtcspi_target rtcspi_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .miso_o(miso_o),
  .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o), .alarm_i(alarm_i),
  .ctrl_o(ctrl_o), .alarm_flag_o(alarm_flag_o)
);

// File: tb/rtcspi_target_tb_top.sv
`timescale 1ns/1ps
module rtcspi_target_tb_top;
  localparam real HALF = 250.0;  // 2 MHz SCLK

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sclk = 1'b0, cs = 1'b0, mosi = 1'b0;
  logic       miso, bus_rd, bus_wr;
  logic [6:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, ctrl, trk;
  logic [1:0] alarm = 2'b00, flags;

  int n_chk = 0, n_fail = 0;
  int wr_cnt = 0, exp_wr_cnt = 0;
  logic [6:0] last_wa;
  logic [7:0] last_wd;

  logic [7:0] ref_ctrl = 8'hC0, ref_trk = 8'h00;
  logic [1:0] ref_stat = 2'b00;
  logic [7:0] ref_ram [96];
  logic [7:0] wbuf [8];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] ext_pat(input logic [6:0] a);
    return ({1'b0, a} * 8'd3) ^ 8'h5A;
  endfunction

  assign bus_rdata = ext_pat(bus_addr);

  rtcspi_target dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_i(cs), .mosi_i(mosi),
    .miso_o(miso), .bus_addr_o(bus_addr), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata), .alarm_i(alarm),
    .ctrl_o(ctrl), .trickle_o(trk), .alarm_flag_o(flags)
  );

  always @(negedge clk) if (bus_wr) begin
    wr_cnt++;
    last_wa = bus_addr;
    last_wd = bus_wdata;
  end

  function automatic logic [7:0] exp_rd(input logic [6:0] a);
    if (a == 7'h0F) return ref_ctrl;
    if (a == 7'h10) return {6'b0, ref_stat};
    if (a == 7'h11) return ref_trk;
    if (a >= 7'h20) return ref_ram[a - 7'h20];
    return ext_pat(a);
  endfunction

  task automatic model_wr(input logic [6:0] a, input logic [7:0] d);
    if (ref_ctrl[6] && a != 7'h0F) return;
    if (a == 7'h0F)      ref_ctrl = d & 8'hC7;
    else if (a == 7'h10) ref_stat = d[1:0];
    else if (a == 7'h11) ref_trk = d;
    else if (a >= 7'h20) ref_ram[a - 7'h20] = d;
    else                 exp_wr_cnt++;
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int k = 0; k < nb; k++) begin
      sclk = 1'b1; mosi = tx[7-k];
      #HALF;
      rx[7-k] = miso;
      sclk = 1'b0;
      #HALF;
    end
  endtask

  task automatic cs_on();  cs = 1'b1; #HALF; endtask
  task automatic cs_off(); #HALF; cs = 1'b0; mosi = 1'b0; #HALF; endtask

  task automatic burst(input bit wr, input logic [6:0] a, input int n, input string req);
    logic [7:0] rx;
    logic [6:0] cur;
    cur = a;
    cs_on();
    xfer({wr, a}, 8, rx);
    for (int i = 0; i < n; i++) begin
      if (wr) begin
        xfer(wbuf[i], 8, rx);
        model_wr(cur, wbuf[i]);
      end else begin
        xfer(8'h00, 8, rx);
        chk(req, rx, exp_rd(cur));
      end
      cur = cur + 1'b1;
    end
    cs_off();
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d, input string req);
    wbuf[0] = d;
    burst(1'b1, a, 1, req);
  endtask

  task automatic pulse_alarm(input logic [1:0] v);
    @(negedge clk); alarm = v;
    @(negedge clk); alarm = 2'b00;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    for (int i = 0; i < 96; i++) ref_ram[i] = 8'h00;
    void'($urandom(32'h5EED_0C1A));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 miso", {7'b0, miso}, 8'h00);
    chk("R11 ctrl", ctrl, 8'hC0);
    chk("R11 trickle", trk, 8'h00);
    chk("R11 flags", {6'b0, flags}, 8'h00);
    chk("R11 strobes", {6'b0, bus_rd, bus_wr}, 8'h00);

    // R3 R4 R6 R7: read ctrl, status, charger in one burst
    burst(1'b0, 7'h0F, 3, "R3/R4/R2 read reset regs");

    // R5 writes under protection
    wr1(7'h20, 8'h55, "R5");
    wr1(7'h05, 8'h77, "R5");
    wr1(7'h11, 8'h3C, "R5");
    chk("R5 no ext write", 8'(wr_cnt), 8'h00);
    chk("R5 trickle", trk, 8'h00);
    burst(1'b0, 7'h20, 1, "R5 ram unchanged");

    // R4 control masking and unprotect
    wr1(7'h0F, 8'hFF, "R4");
    chk("R4 ctrl masked", ctrl, 8'hC7);
    burst(1'b0, 7'h0F, 1, "R4 readback");
    wr1(7'h0F, 8'h07, "R4");
    chk("R4 ctrl clear", ctrl, 8'h07);

    // R9 R2 external write burst
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    burst(1'b1, 7'h12, 3, "R9");
    chk("R9 ext write count", 8'(wr_cnt), 8'(exp_wr_cnt));
    chk("R2 last ext addr", {1'b0, last_wa}, 8'h14);
    chk("R9 last ext data", last_wd, 8'h33);

    // R7 charger register
    wr1(7'h11, 8'hA6, "R7");
    chk("R7 trickle_o", trk, 8'hA6);

    // R9 R2 read burst across region boundaries
    burst(1'b0, 7'h0E, 4, "R9/R2 mixed read");

    // R6 alarm flags
    pulse_alarm(2'b10);
    chk("R6 flag set", {6'b0, flags}, 8'h02);
    ref_stat = 2'b10;
    burst(1'b0, 7'h10, 1, "R6 status read");
    pulse_alarm(2'b01);
    chk("R6 flag accumulate", {6'b0, flags}, 8'h03);
    ref_stat = 2'b11;
    wr1(7'h10, 8'hFE, "R6");
    burst(1'b0, 7'h10, 1, "R6 upper bits zero");
    wr1(7'h10, 8'h00, "R6");
    chk("R6 flag clear", {6'b0, flags}, 8'h00);

    // R8 R2 top of RAM and wrap to 0x00
    wbuf[0] = 8'hE1; wbuf[1] = 8'hF2;
    burst(1'b1, 7'h7E, 2, "R8");
    burst(1'b0, 7'h7F, 2, "R2/R8 wrap");

    // R10 cut mid data byte
    cs_on();
    xfer(8'hA0, 8, rx);
    xfer(8'h11, 8, rx); model_wr(7'h20, 8'h11);
    xfer(8'h99, 5, rx);
    sclk = 1'b0;
    cs_off();
    burst(1'b0, 7'h20, 2, "R10 partial data dropped");
    // R10 cut mid command byte
    cs_on();
    xfer(8'h8F, 3, rx);
    cs_off();
    burst(1'b0, 7'h11, 1, "R10 next is command");
    chk("R10 ctrl untouched", ctrl, 8'h07);

    // R1 R8 seeded random bursts
    for (int t = 0; t < 12; t++) begin
      int sel, n;
      logic [6:0] a;
      bit wr;
      sel = int'($urandom % 3);
      wr  = 1'($urandom);
      if (sel == 0)      begin a = 7'(32'h20 + $urandom % 92); n = 1 + int'($urandom % 4); end
      else if (sel == 1) begin a = 7'h11; n = 1; end
      else               begin a = 7'($urandom % 12); n = 1 + int'($urandom % 3); end
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      burst(wr, a, n, "R1/R8 random");
    end
    for (int i = 0; i < 4; i++) burst(1'b0, 7'(8'h20 + 8'(i * 23)), 2, "R8 sweep");
    chk("R9 total ext writes", 8'(wr_cnt), 8'(exp_wr_cnt));
    chk("R7 final trickle", trk, ref_trk);

    finish_run();
  end
endmodule